// File: doc/BRIEF.md
# Dual-Mode Sample Output Demultiplexer

This block sits behind a converter that delivers one sample per input clock. It hands the samples to downstream logic in one of two modes. A select input picks the mode, and the choice is captured only while the alignment reset is held. In demultiplex mode an internal divide-by-two sequence steers each pair of consecutive samples onto two parallel ports. Both ports update together, and a half-rate output clock goes with them. That clock's rising edge falls midway in the window where the data is stable. In straight mode every sample passes through one register stage to a single port at the full rate, and the output clock is the inverted input clock.

The half-rate clock is not a gated clock. It is a register that toggles inside the input clock domain, controlled by a four-state sequencer. The states are ALIGN (held during reset), TAKE_A (capture the first sample of a pair), TAKE_B (capture the second sample and update both ports) and PASS (straight mode). The transitions are: ALIGN→TAKE_B in demultiplex mode, where the ALIGN exit edge itself captures the first sample; ALIGN→PASS in straight mode; TAKE_B→TAKE_A; TAKE_A→TAKE_B; and PASS→PASS. The reset sends every state to ALIGN. Because the reset fixes the divider phase, several instances that share one reset pulse produce identical port pairing and identical output clocks.

Top module: `sample_demux`

## Requirements
- R1: The mode input is sampled only on edges where the reset is high (1 = demultiplex, 0 = straight). A change of the mode input while the reset is low does not change the ports or the output clock.
- R2: On every edge where the reset is high, both ports become zero and the demultiplex output clock level becomes 0.
- R3: In demultiplex mode, take the sample present at the first edge after reset release and the sample present at the next edge. Port A shows the first and port B the second, both after that second edge. The pattern then repeats every two edges, so port A has a latency of two input clocks and port B of one.
- R4: In demultiplex mode the output clock is 1 after each first-of-pair edge and 0 after each port-update edge. It starts at 1 after the first edge following release, so the ports change only on its falling edge and are stable across its rising edge.
- R5: In straight mode, port A shows the sample present at the previous edge (one register stage) and port B stays zero.
- R6: In straight mode the output clock equals the inverted input clock.
- R7: Two instances whose dividers were out of phase produce identical ports and output clocks after a shared reset pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock, one sample per rising edge |
| align_rst | input | 1 | Synchronous active-high reset; also latches the mode |
| mode_sel | input | 1 | 1 = demultiplex mode, 0 = straight mode |
| sample_in | input | DATA_W | Incoming sample |
| port_a | output | DATA_W | First sample of a pair, or the straight-mode output |
| port_b | output | DATA_W | Second sample of a pair; zero in straight mode |
| out_clk | output | 1 | Half-rate clock (demultiplex) or inverted input clock (straight) |

## Verification
The bench sweeps both modes across several reset lengths and feeds a counting pattern. The ports and the output clock are compared every cycle against an arithmetic model of the pairing. A design with swapped ports, or with a divider that starts in the wrong phase, would pair samples wrongly: its two ports would differ by one count in the wrong direction, or would update while the output clock is high. A mid-run flip of the mode input catches a design that follows the select live instead of latching it. Two instances are started out of phase and then reset together, which exposes a divider that ignores the reset.

// File: rtl/sample_demux_pkg.sv
package sample_demux_pkg;
    typedef enum logic [1:0] {
        ST_ALIGN  = 2'd0,
        ST_TAKE_A = 2'd1,
        ST_TAKE_B = 2'd2,
        ST_PASS   = 2'd3
    } seq_state_t;
endpackage

// File: rtl/sample_demux_seq.sv
module sample_demux_seq
    import sample_demux_pkg::*;
(
    input  logic       clk,
    input  logic       align_rst,
    input  logic       mode_sel,
    output seq_state_t state_o,
    output logic       demux_o,
    output logic       div_o
);
    seq_state_t state_q, state_d;
    logic       mode_q;
    logic       div_q, div_d;

    // state register
    always_ff @(posedge clk) begin
        if (align_rst) state_q <= ST_ALIGN;
        else           state_q <= state_d;
    end

    // next state and next divider level
    always_comb begin
        state_d = state_q;
        div_d   = div_q;
        unique case (state_q)
            ST_ALIGN: begin
                if (mode_q) begin
                    state_d = ST_TAKE_B;
                    div_d   = 1'b1;
                end else begin
                    state_d = ST_PASS;
                    div_d   = 1'b0;
                end
            end
            ST_TAKE_A: begin
                state_d = ST_TAKE_B;
                div_d   = 1'b1;
            end
            ST_TAKE_B: begin
                state_d = ST_TAKE_A;
                div_d   = 1'b0;
            end
            ST_PASS: begin
                state_d = ST_PASS;
                div_d   = 1'b0;
            end
        endcase
    end

    // outputs: latched mode and half-rate clock register
    always_ff @(posedge clk) begin
        if (align_rst) begin
            mode_q <= mode_sel;
            div_q  <= 1'b0;
        end else begin
            div_q  <= div_d;
        end
    end

    assign state_o = state_q;
    assign demux_o = mode_q;
    assign div_o   = div_q;

    // R4: in demultiplex mode the half-rate clock toggles on every edge
    p_div_toggle_r4: assert property (@(posedge clk) disable iff (align_rst)
        (mode_q && state_q != ST_ALIGN && !$past(align_rst)) |-> (div_q != $past(div_q)));
endmodule

// File: rtl/sample_demux_path.sv
module sample_demux_path
    import sample_demux_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              align_rst,
    input  seq_state_t        state_i,
    input  logic              demux_i,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] port_a,
    output logic [DATA_W-1:0] port_b
);
    logic [DATA_W-1:0] hold_q;

    always_ff @(posedge clk) begin
        if (align_rst) begin
            hold_q <= '0;
            port_a <= '0;
            port_b <= '0;
        end else begin
            unique case (state_i)
                ST_ALIGN: begin
                    if (demux_i) hold_q <= din;
                    else         port_a <= din;
                end
                ST_TAKE_A: hold_q <= din;
                ST_TAKE_B: begin
                    port_a <= hold_q;
                    port_b <= din;
                end
                ST_PASS: port_a <= din;
            endcase
        end
    end

    // R3: an update edge shows the previous sample on A and the current on B
    p_pair_r3: assert property (@(posedge clk) disable iff (align_rst)
        (state_i == ST_TAKE_B) |=> (port_b == $past(din) && port_a == $past(din, 2)));

    // R5: straight mode is a single register stage with port B at zero
    p_pass_r5: assert property (@(posedge clk) disable iff (align_rst)
        (state_i == ST_PASS || (state_i == ST_ALIGN && !demux_i))
            |=> (port_a == $past(din) && port_b == '0));
endmodule

// File: rtl/sample_demux_clkout.sv
module sample_demux_clkout (
    input  logic clk,
    input  logic demux_i,
    input  logic div_i,
    output logic out_clk
);
    always_comb begin
        if (demux_i) out_clk = div_i;
        else         out_clk = ~clk;
    end
endmodule

// File: rtl/sample_demux.sv
module sample_demux
    import sample_demux_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              align_rst,
    input  logic              mode_sel,
    input  logic [DATA_W-1:0] sample_in,
    output logic [DATA_W-1:0] port_a,
    output logic [DATA_W-1:0] port_b,
    output logic              out_clk
);
    seq_state_t state_w;
    logic       demux_w;
    logic       div_w;

    sample_demux_seq u_seq (
        .clk       (clk),
        .align_rst (align_rst),
        .mode_sel  (mode_sel),
        .state_o   (state_w),
        .demux_o   (demux_w),
        .div_o     (div_w)
    );

    sample_demux_path #(.DATA_W(DATA_W)) u_path (
        .clk       (clk),
        .align_rst (align_rst),
        .state_i   (state_w),
        .demux_i   (demux_w),
        .din       (sample_in),
        .port_a    (port_a),
        .port_b    (port_b)
    );

    sample_demux_clkout u_clk (
        .clk     (clk),
        .demux_i (demux_w),
        .div_i   (div_w),
        .out_clk (out_clk)
    );

    // R2: a reset edge clears both ports and the divider level
    p_clear_r2: assert property (@(posedge clk)
        align_rst |=> (port_a == '0 && port_b == '0 && div_w == 1'b0));

    // R4: ports hold still across the rising half-rate edge
    p_steady_r4: assert property (@(posedge clk) disable iff (align_rst)
        (demux_w && $rose(div_w)) |-> ($stable(port_a) && $stable(port_b)));
endmodule

// File: tb/sample_demux_tb.sv
module sample_demux_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst_shared = 1'b1;
    logic          rst_extra = 1'b0;
    logic          mode_sel = 1'b1;
    logic [DW-1:0] sample_in = '0;
    logic [DW-1:0] a_i, b_i, a_j, b_j;
    logic          oc_i, oc_j;
    logic          rst_j;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    // reference model state
    bit            m_mode;
    int            m_n;
    logic [DW-1:0] m_hold, m_a, m_b;
    bit            m_clk;

    assign rst_j = rst_shared | rst_extra;

    always #(CLK_PERIOD/2) clk = ~clk;

    sample_demux #(.DATA_W(DW)) dut_i (
        .clk(clk), .align_rst(rst_shared), .mode_sel(mode_sel),
        .sample_in(sample_in), .port_a(a_i), .port_b(b_i), .out_clk(oc_i));

    sample_demux #(.DATA_W(DW)) dut_j (
        .clk(clk), .align_rst(rst_j), .mode_sel(mode_sel),
        .sample_in(sample_in), .port_a(a_j), .port_b(b_j), .out_clk(oc_j));

    task automatic chk(input string tag, input int got, input int exp);
        n_checks++;
        if (got != exp) begin
            n_errors++;
            $display("FAIL %s: got %0d expected %0d", tag, got, exp);
        end
    endtask

    // drive one sample, pass one rising edge, update the model, compare
    task automatic step(input logic [DW-1:0] v, input string tag_data, input string tag_clk);
        sample_in = v;
        @(posedge clk);
        #1;
        if (rst_shared) begin
            m_mode = mode_sel;
            m_n = 0; m_a = '0; m_b = '0; m_clk = 1'b0; m_hold = '0;
        end else begin
            m_n++;
            if (m_mode) begin
                if (m_n % 2 == 1) begin
                    m_hold = v; m_clk = 1'b1;
                end else begin
                    m_a = m_hold; m_b = v; m_clk = 1'b0;
                end
            end else begin
                m_a = v; m_b = '0;
            end
        end
        chk({tag_data, " port_a"}, int'(a_i), int'(m_a));
        chk({tag_data, " port_b"}, int'(b_i), int'(m_b));
        if (m_mode || rst_shared) chk({tag_clk, " out_clk"}, int'(oc_i), int'(m_clk));
        else                      chk({tag_clk, " out_clk high phase"}, int'(oc_i), 0);
    endtask

    initial begin
        // reset state (R2)
        rst_shared = 1'b1; mode_sel = 1'b1;
        step(8'h5a, "R2", "R2");
        step(8'ha5, "R2", "R2");

        // sweep both modes over several reset lengths
        for (int md = 1; md >= 0; md--) begin
            for (int rl = 1; rl <= 3; rl++) begin
                rst_shared = 1'b1; mode_sel = md[0];
                for (int r = 0; r < rl; r++) step(8'(8'hf0 + r), "R2", "R2");
                rst_shared = 1'b0;
                for (int k = 0; k < 24; k++) begin
                    if (md == 1) step(8'(rl * 40 + k), "R3", "R4");
                    else         step(8'(rl * 40 + k), "R5", "R6");
                end
                if (md == 0) begin
                    @(negedge clk); #1;
                    chk("R6 out_clk low phase", int'(oc_i), 1);
                end
                // R1: flip the select while running; nothing may change
                mode_sel = ~md[0];
                for (int k = 0; k < 10; k++) step(8'(200 + k), "R1", "R1");
            end
        end

        // R7: misalign two instances, then reset them together
        mode_sel = 1'b1; rst_shared = 1'b1; rst_extra = 1'b1;
        step(8'd0, "R2", "R2");
        rst_shared = 1'b0;
        step(8'd1, "R3", "R4");
        rst_extra = 1'b0;
        for (int k = 0; k < 5; k++) begin
            step(8'(2 + k), "R3", "R4");
            chk("R7 phases differ before shared reset", int'(oc_i != oc_j), 1);
        end
        rst_shared = 1'b1;
        step(8'd9, "R2", "R2");
        rst_shared = 1'b0;
        for (int k = 0; k < 20; k++) begin
            step(8'(100 + 3 * k), "R3", "R4");
            chk("R7 port_a match", int'(a_j), int'(a_i));
            chk("R7 port_b match", int'(b_j), int'(b_i));
            chk("R7 out_clk match", int'(oc_j), int'(oc_i));
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end
endmodule